// File: doc/BRIEF.md
# Receive FIFO with Switchable Depth and Trigger Table

This block holds the receive byte queue of a 16550-style serial port together with the host-written FIFO control byte. The receive shifter pushes bytes in, and the host pops them from the head. A trigger flag tells the interrupt logic when enough bytes have collected. A strap input, `ext_strap`, sets the mode. When the strap is high the block behaves as a plain 16-byte FIFO. When it is low, control bit 5 can deepen the queue to 64 bytes and switch to a coarser trigger table. In the same mode, control bit 4 arms automatic RTS flow control, which the block hands to the modem-control logic as `auto_rts_en`.

A second agent, the subsystem, cannot write the control byte but reads a view of it on `sub_fcr`. In that view the two self-clearing reset positions always read as one. The depth and flow-control positions are inverted, so they read zero only when the enhanced mode really applies them.

Top module: `rx_fifo_ctl`

## Requirements
- R1: While `ext_strap` is high, `auto_rts_en` is 0 and the queue holds at most 16 bytes, whatever control bits 4 and 5 hold.
- R2: While `ext_strap` is low, `auto_rts_en` equals the last written control bit 4.
- R3: While `ext_strap` is low, control bit 5 set gives a 64-byte queue and bit 5 clear gives a 16-byte queue; `level` never exceeds the active depth.
- R4: In 64-byte mode, control bits 7:6 = 00, 01, 10, 11 select trigger thresholds of 1, 16, 32 and 56 bytes.
- R5: In 16-byte mode, control bits 7:6 = 00, 01, 10, 11 select trigger thresholds of 1, 4, 8 and 14 bytes.
- R6: `trig` is high exactly when `level` is greater than or equal to the selected threshold.
- R7: The control byte is loaded only by a host write at `host_addr` = 2; writes to other offsets leave it and the queue unchanged.
- R8: `sub_fcr` bits 2:1 read 1; bit 4 (bit 5) reads 0 only when `ext_strap` is low and the host has set control bit 4 (bit 5); bits 0, 3, 7 and 6 mirror the same control bits.
- R9: A push while the queue is at its active depth with no pop in the same cycle discards the byte and sets the sticky `overrun` flag.
- R10: A control write with bit 1 set empties the queue and clears `overrun` on the next edge; bit 1 is not retained.
- R11: When the active depth drops from 64 to 16 bytes, the queue is emptied on the next edge.
- R12: Bytes leave in the order they entered; a pop on an empty queue has no effect.
- R13: After reset, `level` is 0, `trig`, `overrun` and `auto_rts_en` are 0, and `sub_fcr` reads 0x36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_strap | input | 1 | High selects base mode; low allows enhanced mode |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| push | input | 1 | Push a received byte |
| push_data | input | 8 | Byte from the receive shifter |
| pop | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte of the queue |
| level | output | 7 | Current occupancy |
| trig | output | 1 | Occupancy at or above the threshold |
| overrun | output | 1 | Sticky overflow flag |
| auto_rts_en | output | 1 | Automatic RTS enable to the modem-control logic |
| sub_fcr | output | 8 | Subsystem read-only view of the control byte |

## Verification
The bound checker watches, on every cycle, the strap's veto of automatic RTS, the depth ceiling on `level`, the overrun set condition, both flush paths, the agreement between the readback and the RTS enable, and the stillness of an empty queue under pop. Only the bench can show the byte order through the queue, the exact threshold reached for each table code, the full readback encoding across strap and control combinations, and that writes to other offsets leave everything unchanged.

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
  parameter int DW       = 8,
  parameter int DEEP     = 64,
  parameter int SHALLOW  = 16,
  parameter int AW       = 3,
  parameter int FCR_ADDR = 2,
  localparam int CW      = $clog2(DEEP + 1),
  localparam int PW      = $clog2(DEEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_strap,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] level,
  output logic          trig,
  output logic          overrun,
  output logic          auto_rts_en,
  output logic [7:0]    sub_fcr
);

  logic [DW-1:0] mem [DEEP];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cap, thr;
  logic [7:0]    fcr_q;
  logic          deep_q, ovr_q;

  wire fcr_we  = host_wr && (host_addr == AW'(FCR_ADDR));
  wire deep    = !ext_strap && fcr_q[5];
  wire shrink  = deep_q && !deep;
  wire flush   = shrink || (fcr_we && host_wdata[1]);
  wire full    = count >= cap;
  wire do_pop  = pop && (count != '0);
  wire do_push = push && (!full || do_pop);
  wire ovr_set = push && full && !do_pop;

  assign cap = deep_q ? CW'(DEEP) : CW'(SHALLOW);

  always_comb begin
    unique case ({deep_q, fcr_q[7:6]})
      3'b000:  thr = CW'(1);
      3'b001:  thr = CW'(4);
      3'b010:  thr = CW'(8);
      3'b011:  thr = CW'(14);
      3'b100:  thr = CW'(1);
      3'b101:  thr = CW'(16);
      3'b110:  thr = CW'(32);
      default: thr = CW'(56);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q  <= '0;
      deep_q <= 1'b0;
    end else begin
      deep_q <= deep;
      if (fcr_we) fcr_q <= host_wdata & 8'hF9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (ovr_set) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  assign pop_data    = mem[rd_ptr];
  assign level       = count;
  assign trig        = count >= thr;
  assign overrun     = ovr_q;
  assign auto_rts_en = !ext_strap && fcr_q[4];
  assign sub_fcr     = {fcr_q[7:6],
                        ~(!ext_strap && fcr_q[5]),
                        ~(!ext_strap && fcr_q[4]),
                        fcr_q[3], 2'b11, fcr_q[0]};

endmodule

// File: rtl/rx_fifo_ctl_chk.sv
module rx_fifo_ctl_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_strap,
  input logic          host_wr,
  input logic [2:0]    host_addr,
  input logic [7:0]    host_wdata,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] level,
  input logic          trig,
  input logic          overrun,
  input logic          auto_rts_en,
  input logic [7:0]    sub_fcr,
  input logic          deep_q
);

  AST_BASE_NO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_strap |-> !auto_rts_en); // R1

  AST_RTS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_strap && host_wr && host_addr == 3'd2) |=> (ext_strap || auto_rts_en == $past(host_wdata[4]))); // R2

  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (deep_q ? CW'(64) : CW'(16))); // R3

  AST_TRIG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= CW'(56)) |-> trig); // R6

  AST_TRIG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> !trig); // R6

  AST_SUB_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fcr[4] == !auto_rts_en); // R8

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !host_wr && !ext_strap && deep_q && level == CW'(64)) |=> overrun); // R9

  AST_FCR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd2 && host_wdata[1]) |=> (level == '0 && !overrun)); // R10

  AST_SHRINK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_strap && level > CW'(16)) |=> (level == '0)); // R11

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && pop && !push) |=> (level == '0)); // R12

endmodule

bind rx_fifo_ctl rx_fifo_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_strap(ext_strap), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata), .push(push), .pop(pop),
  .level(level), .trig(trig), .overrun(overrun), .auto_rts_en(auto_rts_en),
  .sub_fcr(sub_fcr), .deep_q(deep_q)
);

// File: tb/rx_fifo_ctl_bench.sv
module rx_fifo_ctl_bench;
  logic       clk = 0, rst_n = 0, ext_strap = 1;
  logic       host_wr = 0, push = 0, pop = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, push_data = 0, pop_data, sub_fcr;
  logic [6:0] level;
  logic       trig, overrun, auto_rts_en;
  int         nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  rx_fifo_ctl u_rx_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ext_strap(ext_strap), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .push(push),
    .push_data(push_data), .pop(pop), .pop_data(pop_data), .level(level),
    .trig(trig), .overrun(overrun), .auto_rts_en(auto_rts_en), .sub_fcr(sub_fcr)
  );

  // {strap, control byte written, expected readback, expected auto-RTS}
  localparam logic [17:0] VEC [7] = '{
    {1'b1, 8'h30, 8'h36, 1'b0},
    {1'b0, 8'h30, 8'h06, 1'b1},
    {1'b0, 8'h10, 8'h26, 1'b1},
    {1'b0, 8'h20, 8'h16, 1'b0},
    {1'b0, 8'hC9, 8'hFF, 1'b0},
    {1'b1, 8'hF9, 8'hFF, 1'b0},
    {1'b0, 8'h79, 8'h4F, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_fcr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk); push = 1; push_data = d;
    @(negedge clk); push = 0;
  endtask

  task automatic pop_byte(input string req, input logic [7:0] exp);
    @(negedge clk); chk(req, pop_data, exp); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R13 level", level, 0);
    chk("R13 trig", trig, 0);
    chk("R13 overrun", overrun, 0);
    chk("R13 rts", auto_rts_en, 0);
    chk("R13 sub_fcr", sub_fcr, 8'h36);

    for (int i = 0; i < 7; i++) begin
      ext_strap = VEC[i][17];
      wr_fcr(3'd2, VEC[i][16:9]);
      chk("R8 sub_fcr vector", sub_fcr, VEC[i][8:1]);
      chk("R1 R2 rts vector", auto_rts_en, VEC[i][0]);
    end

    // shallow mode, threshold code 10 -> 8
    ext_strap = 0;
    wr_fcr(3'd2, 8'h82);
    chk("R10 flush level", level, 0);
    for (int i = 0; i < 7; i++) push_byte(8'(i));
    chk("R5 below threshold", trig, 0);
    push_byte(8'd7);
    chk("R5 R6 at threshold", trig, 1);
    for (int i = 8; i < 16; i++) push_byte(8'(i));
    chk("R3 shallow full", level, 16);
    chk("R9 no overrun yet", overrun, 0);
    push_byte(8'hAA);
    chk("R9 overrun set", overrun, 1);
    chk("R9 byte dropped", level, 16);
    for (int i = 0; i < 16; i++) pop_byte("R12 order", 8'(i));
    chk("R12 drained", level, 0);
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    chk("R12 pop on empty", level, 0);
    chk("R9 overrun sticky", overrun, 1);

    // deep mode, threshold code 11 -> 56
    wr_fcr(3'd2, 8'hE2);
    chk("R10 overrun cleared", overrun, 0);
    for (int i = 0; i < 55; i++) push_byte(8'(i));
    chk("R4 below 56", trig, 0);
    push_byte(8'd55);
    chk("R4 at 56", trig, 1);
    for (int i = 56; i < 64; i++) push_byte(8'(i));
    chk("R3 deep full", level, 64);
    push_byte(8'hBB);
    chk("R9 deep overrun", overrun, 1);
    chk("R9 deep level held", level, 64);

    // strap rises: depth falls to 16, queue flushed
    @(negedge clk); ext_strap = 1;
    @(negedge clk);
    chk("R11 shrink flush", level, 0);
    chk("R1 rts vetoed", auto_rts_en, 0);
    for (int i = 0; i < 20; i++) push_byte(8'(i));
    chk("R1 base depth", level, 16);

    // strap falls: deep again with 16 queued
    @(negedge clk); ext_strap = 0;
    @(negedge clk);
    wr_fcr(3'd2, 8'h60);
    chk("R4 code 01 reached", trig, 1);
    wr_fcr(3'd2, 8'hA0);
    chk("R4 code 10 not reached", trig, 0);
    wr_fcr(3'd3, 8'h00);
    chk("R7 other offset sub_fcr", sub_fcr, 8'h96);
    chk("R7 other offset level", level, 16);
    chk("R2 rts off", auto_rts_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule